// File: doc/BRIEF.md
# Instruction Front-End Byte Parser

This block sits at the head of a decode path for a 16-bit two-operand instruction set and takes the instruction stream one byte at a time. Bytes are accepted on a valid/ready handshake. The parser first absorbs any number of one-byte modifier bytes. These modifiers select a segment register, change the operand or address width, or request repetition. The first byte that is not a modifier is kept as the opcode, and the byte after it is split into its addressing-mode fields.

The mode fields decide whether a signed displacement of one or two bytes follows. If it does, the parser collects it and widens it to 16 bits. Once the instruction front is complete, the parser holds one decoded record on an output valid/ready handshake. While that record waits, it accepts no further input. When the record is taken, every modifier flag clears and the parser looks for modifiers again. Only opcodes that always carry an addressing-mode byte are fed to it.

Top module: `insn_front_parser`

## Requirements
- R1: After synchronous reset, out_valid is 0, in_ready is 1 and every modifier flag (out_seg_valid, out_opsize, out_adsize, out_rep) is 0.
- R2: Before the opcode, the bytes 26h, 2Eh, 36h and 3Eh set out_seg_valid and load out_seg with 0 (ES), 1 (CS), 2 (SS) or 3 (DS). When several such bytes appear, the last one is reported.
- R3: Before the opcode, byte 66h sets out_opsize, byte 67h sets out_adsize, and either F2h or F3h sets out_rep.
- R4: The first accepted byte that is not one of the seven modifier codes is reported as out_opcode.
- R5: The byte after the opcode is split as mod = bits 7..6, reg = bits 5..3 and r/m = bits 2..0. For example, 8Bh DAh yields opcode 8Bh, mod 3, reg 3, r/m 2.
- R6: With mod = 3, out_reg_only is 1, out_disp_len is 0, out_disp is 0, and the record is valid right after the mode byte.
- R7: With mod = 0, no displacement follows (out_disp_len 0, out_disp 0), except when r/m = 6. In that case two bytes follow, low byte first, and out_disp_len is 2.
- R8: With mod = 1, exactly one displacement byte follows. It is reported sign-extended to 16 bits, and out_disp_len is 1.
- R9: With mod = 2, two displacement bytes follow, low byte first. They form out_disp, and out_disp_len is 2.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1, every record field stays unchanged and in_ready is 0.
- R11: After the record is taken, all modifier flags are 0 and in_ready is 1. An instruction that follows without modifiers reports no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Parser can take a byte |
| out_valid | output | 1 | Decoded record available |
| out_ready | input | 1 | Consumer takes the record |
| out_seg_valid | output | 1 | A segment modifier was seen |
| out_seg | output | 2 | Segment: 0 ES, 1 CS, 2 SS, 3 DS |
| out_opsize | output | 1 | Operand-width modifier seen |
| out_adsize | output | 1 | Address-width modifier seen |
| out_rep | output | 1 | Repeat modifier seen |
| out_opcode | output | 8 | Opcode byte |
| out_mod | output | 2 | Mode field |
| out_reg | output | 3 | Register or secondary-opcode field |
| out_rm | output | 3 | Register/memory field |
| out_reg_only | output | 1 | Both operands are registers |
| out_disp_len | output | 2 | Number of displacement bytes consumed (0, 1, 2) |
| out_disp | output | 16 | Sign-extended displacement |

## Verification
Each accepted byte updates the state at the clock edge that accepts it. The record therefore appears on out_valid one cycle after the final byte of the instruction front is accepted. That final byte is the mode byte when no displacement follows, otherwise the last displacement byte. The bench drives inputs and the ready signal on the falling edge. It compares a record against the scoreboard only at the falling edge where out_valid and the newly set out_ready are both high, which is where the handshake will complete at the next rising edge. Stall cycles are checked at every falling edge that follows a cycle in which out_valid was high and out_ready low. At those edges the bench verifies that the record held still and that in_ready was low.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
    localparam int BYTE_W = 8;
    localparam int DISP_W = 16;

    typedef enum logic [2:0] {
        ST_PFX   = 3'd0,
        ST_MODRM = 3'd1,
        ST_DLO   = 3'd2,
        ST_DHI   = 3'd3,
        ST_DONE  = 3'd4
    } state_e;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    typedef enum logic [2:0] {
        PK_NONE = 3'd0,
        PK_SEG  = 3'd1,
        PK_OPSZ = 3'd2,
        PK_ADSZ = 3'd3,
        PK_REP  = 3'd4
    } pfx_kind_e;

    typedef struct packed {
        state_e              st;
        logic                seg_v;
        seg_e                seg;
        logic                opsz;
        logic                adsz;
        logic                rep;
        logic [BYTE_W-1:0]   opcode;
        logic [1:0]          md;
        logic [2:0]          rg;
        logic [2:0]          rm;
        logic [1:0]          dlen;
        logic [DISP_W-1:0]   disp;
    } parse_t;
endpackage

// File: rtl/ifp_prefix_decode.sv
module ifp_prefix_decode
    import ifp_pkg::*;
#(
    parameter logic [7:0] CODE_OPSZ = 8'h66,
    parameter logic [7:0] CODE_ADSZ = 8'h67,
    parameter logic [7:0] CODE_REPE = 8'hF3,
    parameter logic [7:0] CODE_REPN = 8'hF2
) (
    input  logic [BYTE_W-1:0] byte_i,
    output pfx_kind_e         kind_o,
    output seg_e              seg_o
);
    always_comb begin
        kind_o = PK_NONE;
        seg_o  = SEG_ES;
        unique case (byte_i)
            8'h26:     begin kind_o = PK_SEG; seg_o = SEG_ES; end
            8'h2E:     begin kind_o = PK_SEG; seg_o = SEG_CS; end
            8'h36:     begin kind_o = PK_SEG; seg_o = SEG_SS; end
            8'h3E:     begin kind_o = PK_SEG; seg_o = SEG_DS; end
            CODE_OPSZ: kind_o = PK_OPSZ;
            CODE_ADSZ: kind_o = PK_ADSZ;
            CODE_REPE: kind_o = PK_REP;
            CODE_REPN: kind_o = PK_REP;
            default:   kind_o = PK_NONE;
        endcase
    end
endmodule

// File: rtl/ifp_modrm_split.sv
module ifp_modrm_split
    import ifp_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic [1:0]        md_o,
    output logic [2:0]        rg_o,
    output logic [2:0]        rm_o,
    output logic [1:0]        dlen_o
);
    localparam logic [2:0] RM_DIRECT = 3'b110;

    always_comb begin
        md_o = byte_i[7:6];
        rg_o = byte_i[5:3];
        rm_o = byte_i[2:0];
        unique case (byte_i[7:6])
            2'b00:   dlen_o = (byte_i[2:0] == RM_DIRECT) ? 2'd2 : 2'd0;
            2'b01:   dlen_o = 2'd1;
            2'b10:   dlen_o = 2'd2;
            default: dlen_o = 2'd0;
        endcase
    end
endmodule

// File: rtl/insn_front_parser.sv
module insn_front_parser
    import ifp_pkg::*;
#(
    parameter logic [7:0] CODE_OPSZ = 8'h66,
    parameter logic [7:0] CODE_ADSZ = 8'h67,
    parameter logic [7:0] CODE_REPE = 8'hF3,
    parameter logic [7:0] CODE_REPN = 8'hF2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_seg_valid,
    output logic [1:0]        out_seg,
    output logic              out_opsize,
    output logic              out_adsize,
    output logic              out_rep,
    output logic [BYTE_W-1:0] out_opcode,
    output logic [1:0]        out_mod,
    output logic [2:0]        out_reg,
    output logic [2:0]        out_rm,
    output logic              out_reg_only,
    output logic [1:0]        out_disp_len,
    output logic [DISP_W-1:0] out_disp
);
    localparam int HALF_W = DISP_W / 2;

    parse_t    p_d, p_q;
    pfx_kind_e pk;
    seg_e      pseg;
    logic [1:0] m_md, m_dlen;
    logic [2:0] m_rg, m_rm;
    logic       take;

    ifp_prefix_decode #(
        .CODE_OPSZ(CODE_OPSZ),
        .CODE_ADSZ(CODE_ADSZ),
        .CODE_REPE(CODE_REPE),
        .CODE_REPN(CODE_REPN)
    ) pfx_i (
        .byte_i(in_byte),
        .kind_o(pk),
        .seg_o (pseg)
    );

    ifp_modrm_split modrm_i (
        .byte_i(in_byte),
        .md_o  (m_md),
        .rg_o  (m_rg),
        .rm_o  (m_rm),
        .dlen_o(m_dlen)
    );

    function automatic parse_t idle_state();
        parse_t p;
        p     = '0;
        p.st  = ST_PFX;
        p.seg = SEG_ES;
        return p;
    endfunction

    assign take = in_valid && in_ready;

    always_comb begin
        p_d = p_q;
        unique case (p_q.st)
            ST_PFX: begin
                if (take) begin
                    unique case (pk)
                        PK_SEG:  begin p_d.seg_v = 1'b1; p_d.seg = pseg; end
                        PK_OPSZ: p_d.opsz = 1'b1;
                        PK_ADSZ: p_d.adsz = 1'b1;
                        PK_REP:  p_d.rep  = 1'b1;
                        default: begin
                            p_d.opcode = in_byte;
                            p_d.st     = ST_MODRM;
                        end
                    endcase
                end
            end
            ST_MODRM: begin
                if (take) begin
                    p_d.md   = m_md;
                    p_d.rg   = m_rg;
                    p_d.rm   = m_rm;
                    p_d.dlen = m_dlen;
                    p_d.disp = '0;
                    p_d.st   = (m_dlen == 2'd0) ? ST_DONE : ST_DLO;
                end
            end
            ST_DLO: begin
                if (take) begin
                    if (p_q.dlen == 2'd1) begin
                        p_d.disp = {{(DISP_W-BYTE_W){in_byte[BYTE_W-1]}}, in_byte};
                        p_d.st   = ST_DONE;
                    end else begin
                        p_d.disp[HALF_W-1:0] = in_byte;
                        p_d.st               = ST_DHI;
                    end
                end
            end
            ST_DHI: begin
                if (take) begin
                    p_d.disp[DISP_W-1:HALF_W] = in_byte;
                    p_d.st                    = ST_DONE;
                end
            end
            ST_DONE: begin
                if (out_ready) begin
                    p_d = idle_state();
                end
            end
            default: p_d = idle_state();
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= idle_state();
        end else begin
            p_q <= p_d;
        end
    end

    assign in_ready      = (p_q.st != ST_DONE);
    assign out_valid     = (p_q.st == ST_DONE);
    assign out_seg_valid = p_q.seg_v;
    assign out_seg       = p_q.seg;
    assign out_opsize    = p_q.opsz;
    assign out_adsize    = p_q.adsz;
    assign out_rep       = p_q.rep;
    assign out_opcode    = p_q.opcode;
    assign out_mod       = p_q.md;
    assign out_reg       = p_q.rg;
    assign out_rm        = p_q.rm;
    assign out_reg_only  = (p_q.md == 2'b11);
    assign out_disp_len  = p_q.dlen;
    assign out_disp      = p_q.disp;
endmodule

// File: rtl/ifp_checker.sv
module ifp_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_seg_valid,
    input logic        out_opsize,
    input logic        out_adsize,
    input logic        out_rep,
    input logic [7:0]  out_opcode,
    input logic [1:0]  out_mod,
    input logic [2:0]  out_rm,
    input logic        out_reg_only,
    input logic [1:0]  out_disp_len,
    input logic [15:0] out_disp
);
    p_no_input_while_held_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_hold_record_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode)
                                       && $stable(out_disp) && $stable(out_mod)));

    p_flags_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid && in_ready && !out_seg_valid
                                      && !out_opsize && !out_adsize && !out_rep));

    p_reg_mode_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mod == 2'b11) |-> (out_reg_only && out_disp_len == 2'd0
                                             && out_disp == 16'h0000));

    p_mod0_nodisp_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mod == 2'b00 && out_rm != 3'b110) |-> (out_disp_len == 2'd0));

    p_sign_ext_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mod == 2'b01) |-> (out_disp_len == 2'd1
                                             && out_disp[15:8] == {8{out_disp[7]}}));
endmodule

bind insn_front_parser ifp_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_seg_valid(out_seg_valid),
    .out_opsize   (out_opsize),
    .out_adsize   (out_adsize),
    .out_rep      (out_rep),
    .out_opcode   (out_opcode),
    .out_mod      (out_mod),
    .out_rm       (out_rm),
    .out_reg_only (out_reg_only),
    .out_disp_len (out_disp_len),
    .out_disp     (out_disp)
);

// File: tb/insn_front_parser_tb_top.sv
`timescale 1ns/1ps
module insn_front_parser_tb_top;
    typedef struct packed {
        logic        seg_v;
        logic [1:0]  seg;
        logic        opsz;
        logic        adsz;
        logic        rep;
        logic [7:0]  opcode;
        logic [1:0]  md;
        logic [2:0]  rg;
        logic [2:0]  rm;
        logic        ro;
        logic [1:0]  dlen;
        logic [15:0] disp;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic in_ready;
    logic out_valid;
    logic out_ready = 1'b0;
    logic out_seg_valid, out_opsize, out_adsize, out_rep, out_reg_only;
    logic [1:0] out_seg, out_mod, out_disp_len;
    logic [2:0] out_reg, out_rm;
    logic [7:0] out_opcode;
    logic [15:0] out_disp;

    int checks = 0;
    int failures = 0;
    bit running = 1'b0;
    bit finished = 1'b0;
    int cyc = 0;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [7:0] stream[8];

    always #10 clk = ~clk;

    insn_front_parser dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_seg_valid(out_seg_valid), .out_seg(out_seg),
        .out_opsize(out_opsize), .out_adsize(out_adsize), .out_rep(out_rep),
        .out_opcode(out_opcode), .out_mod(out_mod), .out_reg(out_reg), .out_rm(out_rm),
        .out_reg_only(out_reg_only), .out_disp_len(out_disp_len), .out_disp(out_disp)
    );

    function automatic exp_t actual();
        exp_t a;
        a = {out_seg_valid, out_seg, out_opsize, out_adsize, out_rep, out_opcode,
             out_mod, out_reg, out_rm, out_reg_only, out_disp_len, out_disp};
        return a;
    endfunction

    function automatic exp_t mk(logic sv, logic [1:0] sg, logic os, logic as, logic rp,
                                logic [7:0] op, logic [7:0] modrm, logic [1:0] dl,
                                logic [15:0] dv);
        exp_t e;
        e = {sv, sg, os, as, rp, op, modrm[7:6], modrm[5:3], modrm[2:0],
             (modrm[7:6] == 2'b11), dl, dv};
        return e;
    endfunction

    // Monitor: decide ready, then compare when the handshake will complete.
    exp_t held;
    bit   was_stalled = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (running) begin
            if (was_stalled) begin
                checks++;
                if (!(out_valid && !in_ready && actual() == held)) begin
                    failures++;
                    $display("FAIL R10 stall hold: valid=%0b in_ready=%0b rec=%h exp=%h",
                             out_valid, in_ready, actual(), held);
                end
            end
            out_ready = (cyc % 3 == 0);
            if (out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R4 unexpected record: act=%h exp=none", actual());
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (actual() != e) begin
                        failures++;
                        $display("FAIL %s record: act=%h exp=%h", t, actual(), e);
                    end
                end
            end
            was_stalled = out_valid && !out_ready;
            held = actual();
        end
    end

    task automatic send_insn(int n, exp_t e, string tag, bit gaps);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int i = 0; i < n; i++) begin
            if (gaps && i[0]) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = stream[i];
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid || !in_ready || out_seg_valid || out_opsize || out_adsize || out_rep) begin
            failures++;
            $display("FAIL R1 reset state: valid=%0b ready=%0b flags=%b exp valid=0 ready=1 flags=0000",
                     out_valid, in_ready, {out_seg_valid, out_opsize, out_adsize, out_rep});
        end
        running = 1'b1;

        // R4 R5 R6: plain register form
        stream[0] = 8'h8B; stream[1] = 8'hDA;
        send_insn(2, mk(0, 2'd0, 0, 0, 0, 8'h8B, 8'hDA, 2'd0, 16'h0000), "R4 R5 R6", 0);

        // R2 last segment wins (DS), R3 operand width and repeat
        stream[0] = 8'h2E; stream[1] = 8'h36; stream[2] = 8'h3E; stream[3] = 8'h66;
        stream[4] = 8'hF3; stream[5] = 8'h8B; stream[6] = 8'hDA;
        send_insn(7, mk(1, 2'd3, 1, 0, 1, 8'h8B, 8'hDA, 2'd0, 16'h0000), "R2 R3", 1);

        // R11: no modifiers after a modified instruction
        stream[0] = 8'h01; stream[1] = 8'hD8;
        send_insn(2, mk(0, 2'd0, 0, 0, 0, 8'h01, 8'hD8, 2'd0, 16'h0000), "R11", 0);

        // R8 negative byte displacement, R2 ES, R3 address width and F2 repeat
        stream[0] = 8'h26; stream[1] = 8'h67; stream[2] = 8'hF2;
        stream[3] = 8'h89; stream[4] = 8'h47; stream[5] = 8'h80;
        send_insn(6, mk(1, 2'd0, 0, 1, 1, 8'h89, 8'h47, 2'd1, 16'hFF80), "R8 R2 R3", 1);

        // R8 positive byte displacement
        stream[0] = 8'h8B; stream[1] = 8'h47; stream[2] = 8'h7F;
        send_insn(3, mk(0, 2'd0, 0, 0, 0, 8'h8B, 8'h47, 2'd1, 16'h007F), "R8", 0);

        // R9 word displacement low byte first
        stream[0] = 8'h8B; stream[1] = 8'h87; stream[2] = 8'h34; stream[3] = 8'h12;
        send_insn(4, mk(0, 2'd0, 0, 0, 0, 8'h8B, 8'h87, 2'd2, 16'h1234), "R9", 1);

        // R7 direct address form
        stream[0] = 8'h8B; stream[1] = 8'h06; stream[2] = 8'hCD; stream[3] = 8'hAB;
        send_insn(4, mk(0, 2'd0, 0, 0, 0, 8'h8B, 8'h06, 2'd2, 16'hABCD), "R7 direct", 0);

        // R7 register-indirect with no displacement
        stream[0] = 8'h8B; stream[1] = 8'h07;
        send_insn(2, mk(0, 2'd0, 0, 0, 0, 8'h8B, 8'h07, 2'd0, 16'h0000), "R7 none", 0);

        // R2 SS with byte displacement
        stream[0] = 8'h36; stream[1] = 8'h03; stream[2] = 8'h5E; stream[3] = 8'hF0;
        send_insn(4, mk(1, 2'd2, 0, 0, 0, 8'h03, 8'h5E, 2'd1, 16'hFFF0), "R2 SS", 1);

        // R2 CS with direct address
        stream[0] = 8'h2E; stream[1] = 8'h8B; stream[2] = 8'h1E; stream[3] = 8'h00; stream[4] = 8'h80;
        send_insn(5, mk(1, 2'd1, 0, 0, 0, 8'h8B, 8'h1E, 2'd2, 16'h8000), "R2 CS R7", 0);

        // R9 with operand width modifier, R3
        stream[0] = 8'h66; stream[1] = 8'h8B; stream[2] = 8'h96; stream[3] = 8'hFF; stream[4] = 8'h7F;
        send_insn(5, mk(0, 2'd0, 1, 0, 0, 8'h8B, 8'h96, 2'd2, 16'h7FFF), "R9 R3", 1);

        // R11 again, R6
        stream[0] = 8'h8B; stream[1] = 8'hC0;
        send_insn(2, mk(0, 2'd0, 0, 0, 0, 8'h8B, 8'hC0, 2'd0, 16'h0000), "R11 R6", 0);

        for (int w = 0; w < 50 && exp_q.size() != 0; w++) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R4 records missing: act=%0d pending exp=0", exp_q.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule